// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a 12-bit multiplying converter. A host writes a data word into a pair of input latches, one for the upper bits and one for the lower bits. The latches sit in front of the DAC register that drives the converter. The host loads the latches with a write strobe that chip select gates. A byte-select control decides whether one write fills both latches or only the lower one. A second write strobe, combined with a transfer strobe, then copies the whole latched word into the DAC register in a single step. The converter output therefore never shows a half-updated word.

The host's control pins are not tied to the system clock. Each one passes through a two-stage synchronizer, together with the data bus, and is then edge-detected. A latch or a transfer takes effect once per strobe pulse, when the strobe deasserts. Data is taken from the last sampled cycle in which the strobe was still asserted, so data may change as soon as the strobe releases. The DAC register drives a full-scale flag and a zero flag.

Top module: `dac_dbuf`

## Requirements
- R1: While rst_ni is low, dac_o is 0x000, zero_o is 1 and full_o is 0.
- R2: A write pulse on wr1_ni with cs_ni low and byte_hi_i high loads data_i[11:8] into the upper latch and data_i[7:0] into the lower latch.
- R3: A write pulse on wr1_ni with cs_ni low and byte_hi_i low loads only the lower latch from data_i[7:0] and leaves the upper latch unchanged.
- R4: A pulse on wr1_ni while cs_ni is high leaves both latches unchanged.
- R5: Loading the latches does not change dac_o until a transfer occurs.
- R6: A pulse on wr2_ni alone, or on xfer_ni alone, does not change dac_o. A transfer needs both strobes low at the same time.
- R7: When the period in which wr2_ni and xfer_ni are both low ends, dac_o takes the latched word {upper[3:0], lower[7:0]}, with bit 0 as the LSB. This happens once per such period.
- R8: full_o is 1 exactly when dac_o is 0xFFF, and zero_o is 1 exactly when dac_o is 0x000. The two flags are never high together.
- R9: A write captures the value data_i held while wr1_ni was low. A change of data_i at the moment wr1_ni releases has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; gates wr1_ni |
| wr1_ni | input | 1 | Latch write strobe, active low |
| wr2_ni | input | 1 | Transfer enable strobe, active low |
| xfer_ni | input | 1 | Transfer strobe, active low |
| byte_hi_i | input | 1 | 1: write both latches; 0: write lower latch only |
| data_i | input | 12 | Data bus, bit 0 LSB |
| dac_o | output | 12 | DAC register value |
| full_o | output | 1 | DAC register holds all ones |
| zero_o | output | 1 | DAC register holds all zeros |

## Verification
The assertions check on every cycle that the reset value of the DAC register is zero and that the two flags are never high together. They also check that dac_o changes only four cycles after a sampled period in which both transfer strobes were low, so that a lone wr2_ni or xfer_ni can never move the output. Only the bench scenarios can show which latch a write reaches under each byte-select value, that chip select blocks a write, and which data value a write captures when data_i changes at the release of the strobe. These cases require values to be compared with the word the host intended to write.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
  localparam int unsigned DataW = 12;
  localparam int unsigned HiW   = 4;

  typedef struct packed {
    logic cs_n;
    logic wr1_n;
    logic wr2_n;
    logic xfer_n;
    logic byte_hi;
  } ctl_t;

  localparam int unsigned CtlW = $bits(ctl_t);
  localparam ctl_t CtlIdle = '{cs_n: 1'b1, wr1_n: 1'b1, wr2_n: 1'b1, xfer_n: 1'b1, byte_hi: 1'b0};
endpackage

// File: rtl/dac_dbuf_sync.sv
module dac_dbuf_sync #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  logic [W-1:0] meta_q, sync_q, prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      prv_q  <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prv_q  <= sync_q;
    end
  end

  assign cur_o = sync_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/dac_dbuf_latch.sv
module dac_dbuf_latch #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned HI_W   = 4,
  localparam int unsigned LoW   = DATA_W - HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              both_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] word_o
);
  logic [HI_W-1:0] hi_q;
  logic [LoW-1:0]  lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (ld_i) begin
      lo_q <= data_i[LoW-1:0];
      if (both_i) hi_q <= data_i[DATA_W-1:LoW];
    end
  end

  assign word_o = {hi_q, lo_q};
endmodule

// File: rtl/dac_dbuf_out.sv
module dac_dbuf_out #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              full_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dac_q <= '0;
    else if (go_i) dac_q <= word_i;
  end

  assign dac_o  = dac_q;
  assign full_o = &dac_q;
  assign zero_o = ~|dac_q;
endmodule

// File: rtl/dac_dbuf.sv
module dac_dbuf
  import dac_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = DataW,
  parameter int unsigned HI_W   = HiW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr1_ni,
  input  logic              wr2_ni,
  input  logic              xfer_ni,
  input  logic              byte_hi_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              full_o,
  output logic              zero_o
);
  localparam int unsigned BusW = CtlW + DATA_W;
  localparam logic [BusW-1:0] BusRst = {CtlIdle, {DATA_W{1'b0}}};

  ctl_t              ctl_in, ctl_cur, ctl_prv;
  logic [DATA_W-1:0] dat_cur, dat_prv;
  logic [BusW-1:0]   bus_cur, bus_prv;
  logic              ld, xfer_act_cur, xfer_act_prv, xfer_go;
  logic [DATA_W-1:0] word;

  always_comb begin
    ctl_in.cs_n    = cs_ni;
    ctl_in.wr1_n   = wr1_ni;
    ctl_in.wr2_n   = wr2_ni;
    ctl_in.xfer_n  = xfer_ni;
    ctl_in.byte_hi = byte_hi_i;
  end

  // data rides with the strobes so capture stays aligned
  dac_dbuf_sync #(.W(BusW), .RST_VAL(BusRst)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ctl_in, data_i}),
    .cur_o (bus_cur),
    .prv_o (bus_prv)
  );

  assign {ctl_cur, dat_cur} = bus_cur;
  assign {ctl_prv, dat_prv} = bus_prv;

  // write completes on strobe release; chip select and data taken while strobe was low
  assign ld = ~ctl_prv.wr1_n & ctl_cur.wr1_n & ~ctl_prv.cs_n;

  assign xfer_act_cur = ~ctl_cur.wr2_n & ~ctl_cur.xfer_n;
  assign xfer_act_prv = ~ctl_prv.wr2_n & ~ctl_prv.xfer_n;
  assign xfer_go      = xfer_act_prv & ~xfer_act_cur;

  dac_dbuf_latch #(.DATA_W(DATA_W), .HI_W(HI_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ld),
    .both_i(ctl_prv.byte_hi),
    .data_i(dat_prv),
    .word_o(word)
  );

  dac_dbuf_out #(.DATA_W(DATA_W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (xfer_go),
    .word_i(word),
    .dac_o (dac_o),
    .full_o(full_o),
    .zero_o(zero_o)
  );
endmodule

// File: rtl/dac_dbuf_chk.sv
module dac_dbuf_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr2_ni,
  input logic              xfer_ni,
  input logic [DATA_W-1:0] dac_o,
  input logic              full_o,
  input logic              zero_o
);
  p_reset_clear_r1: assert property (@(posedge clk_i) !rst_ni |=> dac_o == '0);

  p_flags_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({full_o, zero_o}));

  // synchronizer (2) + edge stage (1) + DAC register (1)
  p_no_spont_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_o) |-> ($past(!wr2_ni, 4) && $past(!xfer_ni, 4)));

  p_wr2_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr2_ni, 4) |-> $stable(dac_o));

  p_xfer_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(xfer_ni, 4) |-> $stable(dac_o));
endmodule

bind dac_dbuf dac_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr2_ni (wr2_ni),
  .xfer_ni(xfer_ni),
  .dac_o  (dac_o),
  .full_o (full_o),
  .zero_o (zero_o)
);

// File: tb/dac_dbuf_tb.sv
module dac_dbuf_tb;
  localparam int unsigned W = 12;

  typedef struct {
    logic [W-1:0] dac;
    logic         full;
    logic         zero;
    string        req;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cs_ni = 1'b1, wr1_ni = 1'b1, wr2_ni = 1'b1, xfer_ni = 1'b1, byte_hi_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] dac_o;
  logic         full_o, zero_o;

  int   total = 0, bad = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #4 clk_i = ~clk_i;

  dac_dbuf u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr1_ni(wr1_ni), .wr2_ni(wr2_ni),
    .xfer_ni(xfer_ni), .byte_hi_i(byte_hi_i), .data_i(data_i),
    .dac_o(dac_o), .full_o(full_o), .zero_o(zero_o)
  );

  task automatic expect_dac(input logic [W-1:0] v, input string req);
    exp_t e;
    repeat (6) @(negedge clk_i);
    e.dac = v; e.full = (v == '1); e.zero = (v == '0); e.req = req;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  // data flips the instant the strobe releases (R9)
  task automatic write1(input logic cs_low, input logic both, input logic [W-1:0] d);
    @(negedge clk_i);
    cs_ni = ~cs_low; byte_hi_i = both; data_i = d;
    @(negedge clk_i);
    wr1_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    wr1_ni = 1'b1; data_i = ~d;
    repeat (3) @(negedge clk_i);
    cs_ni = 1'b1;
  endtask

  task automatic pulse(input logic use_wr2, input logic use_xfer, input int len);
    @(negedge clk_i);
    wr2_ni = ~use_wr2; xfer_ni = ~use_xfer;
    repeat (len) @(negedge clk_i);
    wr2_ni = 1'b1; xfer_ni = 1'b1;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (exp_q.size() != 0);
      e = exp_q[0];
      total++;
      if (dac_o !== e.dac || full_o !== e.full || zero_o !== e.zero) begin
        bad++;
        $display("FAIL %s: dac=%h full=%b zero=%b expected dac=%h full=%b zero=%b",
                 e.req, dac_o, full_o, zero_o, e.dac, e.full, e.zero);
      end
      void'(exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk_i);
    expect_dac(12'h000, "R1");
    rst_ni = 1'b1;

    write1(1'b1, 1'b1, 12'hA5C);
    expect_dac(12'h000, "R5");
    pulse(1'b1, 1'b1, 3);
    expect_dac(12'hA5C, "R2 R7");

    write1(1'b1, 1'b0, 12'h3F1);
    expect_dac(12'hA5C, "R5");
    pulse(1'b1, 1'b1, 2);
    expect_dac(12'hAF1, "R3");

    write1(1'b0, 1'b1, 12'h123);
    pulse(1'b1, 1'b1, 3);
    expect_dac(12'hAF1, "R4");

    write1(1'b1, 1'b1, 12'hFFF);
    pulse(1'b1, 1'b0, 4);
    expect_dac(12'hAF1, "R6 wr2 only");
    pulse(1'b0, 1'b1, 4);
    expect_dac(12'hAF1, "R6 xfer only");
    pulse(1'b1, 1'b1, 10);
    expect_dac(12'hFFF, "R7 R8 full");

    write1(1'b1, 1'b1, 12'h000);
    pulse(1'b1, 1'b1, 3);
    expect_dac(12'h000, "R9 R8 zero");

    write1(1'b1, 1'b1, 12'h001);
    pulse(1'b1, 1'b1, 3);
    expect_dac(12'h001, "R7 lsb");

    write1(1'b1, 1'b1, 12'h800);
    pulse(1'b1, 1'b1, 3);
    expect_dac(12'h800, "R2 msb");

    write1(1'b1, 1'b0, 12'hF7E);
    pulse(1'b1, 1'b1, 3);
    expect_dac(12'h87E, "R3 hi kept");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule